// File: doc/BRIEF.md
# Transmit byte FIFO with fill watermark and transmit start threshold

This block is a single byte-wide transmit queue between a DMA engine that fills it from the bus side and a MAC that drains it on the line side. It has two programmable thresholds. The first is a watermark on free space. While at least that many byte locations are empty, the block asks the DMA engine for more data. The second is a start point on buffered bytes. Once that many bytes of the pending frame are held, the MAC side is allowed to start the frame. A full-packet mode overrides the start point: nothing is released until an entire frame, closed by its end-of-frame byte, sits in the queue.

Both threshold fields sit in a small control register. That register only accepts a load while the stop input or the suspend input is high. Raising stop by itself never alters the fields.

Both data interfaces are valid/ready streams. On the write side, `wr_ready` is low exactly while the queue is full. A byte is taken on a rising edge where `wr_valid` and `wr_ready` are both high. A byte offered while the queue is full is dropped and recorded in a sticky overflow flag. On the read side, `rd_valid` is high only while a frame is in transmission and the queue is not empty. A byte leaves on a rising edge where `rd_valid` and `rd_ready` are both high. Raising `rd_ready` during transmission while the queue is empty records a sticky underflow flag. The hard reset `rst_n` is asynchronous. The soft reset `soft_rst` is synchronous. Either one empties the queue, clears both flags and restores the default field values.

Top module: `txq_thresh`

## Requirements
- R1: After hard or soft reset: start code is 01, watermark code is 00, `fifo_empty`=1, `fifo_full`=0, `free_cnt`=256, `tx_active`=0, and both sticky flags are 0.
- R2: A clock edge with `cfg_we`=1 loads `cfg_wm_code` and `cfg_sp_code` only if `cfg_stop` or `cfg_suspend` is high. Any other edge leaves both fields unchanged, including an edge where only stop is raised.
- R3: Watermark code 00 selects 16 free bytes, 01 selects 64, 10 selects 108, and the reserved code 11 behaves as 00. `dma_req` is high exactly when `free_cnt` is at least the selected value, and it changes in the same cycle as `free_cnt`.
- R4: Start code 00 selects 20 buffered bytes, 01 selects 64, 10 selects 128 and 11 selects 220. When idle, `tx_active` rises one cycle after the byte count reaches the selected value.
- R5: When idle, `tx_active` also rises one cycle after a complete frame is present, whatever the start code.
- R6: With `full_pkt_mode`=1, `tx_active` stays low until a complete frame is buffered, however many bytes are held.
- R7: Once `tx_active` is high it stays high until the end-of-frame byte is read. It is low in the following cycle, and `rd_valid` is low while `tx_active` is low.
- R8: Bytes and their end-of-frame marks leave the read port in the order in which they were accepted.
- R9: While full, `wr_ready`=0. A byte offered then is dropped and `ovf_flag` is set and held until reset.
- R10: `rd_ready`=1 while `tx_active`=1 and the queue is empty sets `udf_flag`, which holds until reset.
- R11: `fifo_full`, `fifo_empty` and `free_cnt` are registers updated on the edge of each accepted transfer. A write and a read on the same edge leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cfg_we | input | 1 | Load strobe for the threshold fields |
| cfg_stop | input | 1 | Stop state; enables field loads |
| cfg_suspend | input | 1 | Suspend state; enables field loads |
| cfg_wm_code | input | 2 | New watermark code |
| cfg_sp_code | input | 2 | New start-point code |
| full_pkt_mode | input | 1 | Hold transmission until a whole frame is buffered |
| wm_code_q | output | 2 | Current watermark code |
| sp_code_q | output | 2 | Current start-point code |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Write byte ends its frame |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | MAC takes the byte |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Read byte ends its frame |
| tx_active | output | 1 | A frame is in transmission |
| dma_req | output | 1 | Free space at or above the watermark |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| free_cnt | output | 9 | Number of free byte locations |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |

## Verification
A transfer accepted on an edge shows in `free_cnt`, `fifo_full`, `fifo_empty` and `dma_req` right after that edge. A field load is visible right after its edge. `tx_active` rises one edge later than the count or frame change that allows it, and it falls on the edge that reads the end-of-frame byte. The bench drives inputs and samples outputs on the falling edge. For each result it waits the exact number of falling edges stated here. It checks the start threshold at both the cycle the count reaches it and the cycle after, so an off-by-one in either direction is caught. The randomized streams compare `free_cnt` and `dma_req` against a byte-count model on every cycle.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    WM_16   = 2'b00,
    WM_64   = 2'b01,
    WM_108  = 2'b10,
    WM_RSVD = 2'b11
  } wm_code_e;

  typedef enum logic [1:0] {
    SP_20  = 2'b00,
    SP_64  = 2'b01,
    SP_128 = 2'b10,
    SP_220 = 2'b11
  } sp_code_e;

  localparam logic [1:0] WM_RESET = WM_16;
  localparam logic [1:0] SP_RESET = SP_64;

  // Free bytes needed before a fill request; the reserved code falls back to 16.
  function automatic int unsigned wm_bytes(input logic [1:0] code);
    case (code)
      WM_64:   return 64;
      WM_108:  return 108;
      default: return 16;
    endcase
  endfunction

  // Buffered bytes needed before a frame may start.
  function automatic int unsigned sp_bytes(input logic [1:0] code);
    case (code)
      SP_20:   return 20;
      SP_64:   return 64;
      SP_128:  return 128;
      default: return 220;
    endcase
  endfunction

endpackage

// File: rtl/txq_storage.sv
module txq_storage #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_last,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          head_last,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] free_q,
  output logic          full_q,
  output logic          empty_q
);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_nxt;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= {push_last, push_data};
  end

  assign {head_last, head_data} = mem[rd_ptr_q];

  always_comb begin
    unique case ({push, pop})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      free_q   <= CW'(DEPTH);
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else if (clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      free_q   <= CW'(DEPTH);
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q   <= cnt_nxt;
      free_q  <= CW'(DEPTH) - cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      empty_q <= (cnt_nxt == '0);
    end
  end

  AST_FREE_PLUS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_q) + 32'(cnt_q)) == DEPTH) else $error("free+count mismatch"); // R11
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q)) else $error("full and empty together"); // R11
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !push) else $error("push while full"); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> !pop) else $error("pop while empty"); // R10

endmodule

// File: rtl/txq_cfg.sv
module txq_cfg
  import txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       we,
  input  logic       stop,
  input  logic       suspend,
  input  logic [1:0] wm_in,
  input  logic [1:0] sp_in,
  output logic [1:0] wm_q,
  output logic [1:0] sp_q
);

  logic load_ok;
  assign load_ok = we && (stop || suspend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q <= WM_RESET;
      sp_q <= SP_RESET;
    end else if (clr) begin
      wm_q <= WM_RESET;
      sp_q <= SP_RESET;
    end else if (load_ok) begin
      wm_q <= wm_in;
      sp_q <= sp_in;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(stop || suspend) && !clr) |=> ($stable(wm_q) && $stable(sp_q)))
    else $error("field changed while unlocked"); // R2
  AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (stop || suspend) && !clr) |=> (wm_q == $past(wm_in) && sp_q == $past(sp_in)))
    else $error("field load lost"); // R2

endmodule

// File: rtl/txq_txctl.sv
module txq_txctl
  import txq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          full_pkt,
  input  logic [1:0]    wm_code,
  input  logic [1:0]    sp_code,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] free_cnt,
  input  logic          empty,
  input  logic          full,
  input  logic          wr_valid,
  input  logic          push,
  input  logic          push_last,
  input  logic          pop,
  input  logic          pop_last,
  input  logic          rd_ready,
  output logic          tx_active_q,
  output logic          dma_req,
  output logic          ovf_q,
  output logic          udf_q
);

  logic [CW-1:0] frames_q;
  logic          frame_in, frame_out, start_ok, tx_done;

  assign frame_in  = push && push_last;
  assign frame_out = pop && pop_last;
  assign tx_done   = tx_active_q && frame_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     frames_q <= '0;
    else if (clr)                   frames_q <= '0;
    else if (frame_in && !frame_out) frames_q <= frames_q + 1'b1;
    else if (frame_out && !frame_in) frames_q <= frames_q - 1'b1;
  end

  always_comb begin
    if (full_pkt) start_ok = (frames_q != '0);
    else          start_ok = (frames_q != '0) || (32'(cnt) >= sp_bytes(sp_code));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tx_active_q <= 1'b0;
    else if (clr)                     tx_active_q <= 1'b0;
    else if (tx_done)                 tx_active_q <= 1'b0;
    else if (!tx_active_q && start_ok) tx_active_q <= 1'b1;
  end

  assign dma_req = (32'(free_cnt) >= wm_bytes(wm_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (clr) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (wr_valid && full)                 ovf_q <= 1'b1;
      if (rd_ready && tx_active_q && empty) udf_q <= 1'b1;
    end
  end

  AST_FULL_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_pkt && !tx_active_q && frames_q == '0) |=> !tx_active_q)
    else $error("started without a whole frame"); // R6
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active_q && !frame_out && !clr) |=> tx_active_q)
    else $error("transmission dropped mid-frame"); // R7
  AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active_q && frame_out) |=> !tx_active_q)
    else $error("transmission not closed after last byte"); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q) else $error("overflow flag cleared"); // R9
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_q && !clr) |=> udf_q) else $error("underflow flag cleared"); // R10
  AST_FRAMES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frames_q <= cnt) else $error("more frames than bytes"); // R5

endmodule

// File: rtl/txq_thresh.sv
module txq_thresh #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          cfg_we,
  input  logic          cfg_stop,
  input  logic          cfg_suspend,
  input  logic [1:0]    cfg_wm_code,
  input  logic [1:0]    cfg_sp_code,
  input  logic          full_pkt_mode,
  output logic [1:0]    wm_code_q,
  output logic [1:0]    sp_code_q,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          tx_active,
  output logic          dma_req,
  output logic          fifo_full,
  output logic          fifo_empty,
  output logic [CW-1:0] free_cnt,
  output logic          ovf_flag,
  output logic          udf_flag
);

  logic          push, pop;
  logic [CW-1:0] cnt;

  assign wr_ready = !fifo_full;
  assign push     = wr_valid && !fifo_full;
  assign rd_valid = tx_active && !fifo_empty;
  assign pop      = rd_valid && rd_ready;

  txq_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .we      (cfg_we),
    .stop    (cfg_stop),
    .suspend (cfg_suspend),
    .wm_in   (cfg_wm_code),
    .sp_in   (cfg_sp_code),
    .wm_q    (wm_code_q),
    .sp_q    (sp_code_q)
  );

  txq_storage #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_rst),
    .push      (push),
    .push_data (wr_data),
    .push_last (wr_last),
    .pop       (pop),
    .head_data (rd_data),
    .head_last (rd_last),
    .cnt_q     (cnt),
    .free_q    (free_cnt),
    .full_q    (fifo_full),
    .empty_q   (fifo_empty)
  );

  txq_txctl #(.DEPTH(DEPTH)) u_txctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (soft_rst),
    .full_pkt    (full_pkt_mode),
    .wm_code     (wm_code_q),
    .sp_code     (sp_code_q),
    .cnt         (cnt),
    .free_cnt    (free_cnt),
    .empty       (fifo_empty),
    .full        (fifo_full),
    .wr_valid    (wr_valid),
    .push        (push),
    .push_last   (wr_last),
    .pop         (pop),
    .pop_last    (rd_last),
    .rd_ready    (rd_ready),
    .tx_active_q (tx_active),
    .dma_req     (dma_req),
    .ovf_q       (ovf_flag),
    .udf_q       (udf_flag)
  );

  AST_RD_VALID_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !rd_valid) else $error("read offered while idle"); // R7

endmodule

// File: tb/txq_thresh_tb.sv
`timescale 1ns/1ps
module txq_thresh_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic cfg_we = 1'b0, cfg_stop = 1'b0, cfg_suspend = 1'b0;
  logic [1:0] cfg_wm_code = 2'b00, cfg_sp_code = 2'b00;
  logic full_pkt_mode = 1'b0;
  logic [1:0] wm_code_q, sp_code_q;
  logic wr_valid = 1'b0, wr_last = 1'b0, wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic rd_valid, rd_last, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic tx_active, dma_req, fifo_full, fifo_empty, ovf_flag, udf_flag;
  logic [8:0] free_cnt;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [8:0] model_q [$];

  always #2 clk = ~clk;

  txq_thresh u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_stop(cfg_stop), .cfg_suspend(cfg_suspend),
    .cfg_wm_code(cfg_wm_code), .cfg_sp_code(cfg_sp_code),
    .full_pkt_mode(full_pkt_mode), .wm_code_q(wm_code_q), .sp_code_q(sp_code_q),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .tx_active(tx_active), .dma_req(dma_req), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .free_cnt(free_cnt), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  function automatic int exp_wm(input logic [1:0] c);
    return (c == 2'b01) ? 64 : (c == 2'b10) ? 108 : 16;
  endfunction

  function automatic int exp_sp(input logic [1:0] c);
    return (c == 2'b00) ? 20 : (c == 2'b01) ? 64 : (c == 2'b10) ? 128 : 220;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic do_soft_reset();
    wr_valid = 1'b0; rd_ready = 1'b0; soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    model_q.delete();
  endtask

  task automatic set_cfg(input logic [1:0] wm, input logic [1:0] sp, input bit via_susp);
    cfg_wm_code = wm; cfg_sp_code = sp; cfg_we = 1'b1;
    cfg_stop = !via_susp; cfg_suspend = via_susp;
    @(negedge clk);
    cfg_we = 1'b0; cfg_stop = 1'b0; cfg_suspend = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d, input bit last);
    wr_valid = 1'b1; wr_data = d; wr_last = last;
    if (wr_ready) model_q.push_back({last, d});
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic write_frame(input int n, input bit close);
    for (int i = 0; i < n; i++) write_byte(8'($urandom), close && (i == n - 1));
  endtask

  task automatic read_byte(input string req);
    logic [8:0] e;
    rd_ready = 1'b1;
    if (rd_valid) begin
      if (model_q.size() == 0) chk(req, 1, 0);
      else begin
        e = model_q.pop_front();
        chk(req, {rd_last, rd_data}, e);
      end
    end
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic drain(input string req);
    while (!fifo_empty) read_byte(req);
  endtask

  task automatic random_run(input bit fp, input int n_cycles);
    int rem = 0;
    logic [1:0] wm;
    bit wv, rr, wacc, racc;
    logic [7:0] d;
    logic [8:0] e;
    do_soft_reset();
    wm = 2'($urandom);
    set_cfg(wm, 2'($urandom), 1'($urandom));
    full_pkt_mode = fp;
    for (int c = 0; c < n_cycles; c++) begin
      chk("R11 free count vs model", free_cnt, 256 - model_q.size());
      chk("R3 dma_req vs watermark", dma_req, (free_cnt >= exp_wm(wm)) ? 1 : 0);
      if (rem == 0) rem = 1 + ($urandom % 200);
      wv = ($urandom % 4) != 0;
      rr = ($urandom % 3) != 0;
      d = 8'($urandom);
      wr_valid = wv; wr_data = d; wr_last = (rem == 1); rd_ready = rr;
      wacc = wv && wr_ready;
      racc = rr && rd_valid;
      if (racc) begin
        if (model_q.size() == 0) chk("R8 read with empty model", 1, 0);
        else begin
          e = model_q.pop_front();
          chk("R8 random order", {rd_last, rd_data}, e);
        end
      end
      if (wacc) begin
        model_q.push_back({rem == 1, d});
        rem--;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0; rd_ready = 1'b0; wr_last = 1'b0;
    full_pkt_mode = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sp code", sp_code_q, 1);
    chk("R1 wm code", wm_code_q, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 free", free_cnt, 256);
    chk("R1 tx_active", tx_active, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 udf", udf_flag, 0);

    // R2 gated loads
    cfg_we = 1'b1; cfg_wm_code = 2'b10; cfg_sp_code = 2'b11;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R2 unlocked wm ignored", wm_code_q, 0);
    chk("R2 unlocked sp ignored", sp_code_q, 1);
    cfg_stop = 1'b1;
    @(negedge clk);
    cfg_stop = 1'b0;
    chk("R2 stop alone keeps sp", sp_code_q, 1);
    set_cfg(2'b10, 2'b11, 1'b1);
    chk("R2 suspend load wm", wm_code_q, 2);
    chk("R2 suspend load sp", sp_code_q, 3);
    set_cfg(2'b01, 2'b00, 1'b0);
    chk("R2 stop load wm", wm_code_q, 1);
    chk("R2 stop load sp", sp_code_q, 0);

    // R3 watermark edge per code
    for (int c = 0; c < 4; c++) begin
      do_soft_reset();
      set_cfg(2'(c), 2'b11, 1'b0);
      write_frame(256 - exp_wm(2'(c)), 1'b0);
      chk("R3 free at watermark", free_cnt, exp_wm(2'(c)));
      chk("R3 dma_req at watermark", dma_req, 1);
      write_byte(8'h5A, 1'b0);
      chk("R3 dma_req below watermark", dma_req, 0);
    end

    // R4 start threshold per code, then R8 order
    for (int c = 0; c < 4; c++) begin
      do_soft_reset();
      set_cfg(2'b00, 2'(c), 1'b0);
      write_frame(exp_sp(2'(c)) - 1, 1'b0);
      @(negedge clk);
      chk("R4 idle below start point", tx_active, 0);
      write_byte(8'hA5, 1'b0);
      chk("R4 not yet active at threshold edge", tx_active, 0);
      @(negedge clk);
      chk("R4 active one cycle later", tx_active, 1);
      write_byte(8'h3C, 1'b1);
      drain("R8 order after start point");
      chk("R7 idle after last byte", tx_active, 0);
    end

    // R5 short complete frame
    do_soft_reset();
    set_cfg(2'b00, 2'b10, 1'b0);
    write_frame(5, 1'b1);
    chk("R5 not active on closing edge", tx_active, 0);
    @(negedge clk);
    chk("R5 short frame starts", tx_active, 1);
    drain("R8 short frame");

    // R6 full-packet hold
    do_soft_reset();
    set_cfg(2'b00, 2'b00, 1'b0);
    full_pkt_mode = 1'b1;
    write_frame(100, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R6 held past start point", tx_active, 0);
    write_byte(8'h77, 1'b1);
    @(negedge clk);
    chk("R6 starts on whole frame", tx_active, 1);
    drain("R8 full packet");
    full_pkt_mode = 1'b0;

    // R7 no re-evaluation mid-frame, restart for next frame
    do_soft_reset();
    set_cfg(2'b00, 2'b10, 1'b0);
    write_frame(5, 1'b1);
    write_frame(3, 1'b1);
    chk("R7 active with frames queued", tx_active, 1);
    for (int i = 0; i < 4; i++) read_byte("R8 frame A");
    chk("R7 stays active mid-frame", tx_active, 1);
    read_byte("R8 frame A last");
    chk("R7 idle after end byte", tx_active, 0);
    chk("R7 rd_valid low while idle", rd_valid, 0);
    @(negedge clk);
    chk("R7 next frame restarts", tx_active, 1);
    drain("R8 frame B");

    // R9 overflow, R10 underflow
    do_soft_reset();
    write_frame(256, 1'b0);
    chk("R9 full", fifo_full, 1);
    chk("R9 wr_ready low", wr_ready, 0);
    chk("R11 free zero", free_cnt, 0);
    chk("R9 ovf clear before", ovf_flag, 0);
    write_byte(8'hEE, 1'b0);
    chk("R9 ovf set", ovf_flag, 1);
    chk("R9 byte dropped", free_cnt, 0);
    drain("R8 after overflow");
    chk("R11 empty", fifo_empty, 1);
    chk("R10 udf clear before", udf_flag, 0);
    chk("R9 ovf still set", ovf_flag, 1);
    read_byte("R10 underflow read");
    chk("R10 udf set", udf_flag, 1);
    @(negedge clk);
    chk("R10 udf sticky", udf_flag, 1);
    do_soft_reset();
    chk("R1 soft reset ovf", ovf_flag, 0);
    chk("R1 soft reset udf", udf_flag, 0);
    chk("R1 soft reset sp", sp_code_q, 1);
    chk("R1 soft reset active", tx_active, 0);

    // R11 simultaneous write and read
    set_cfg(2'b00, 2'b00, 1'b0);
    write_frame(30, 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h11; wr_last = 1'b0; rd_ready = 1'b1;
    model_q.push_back({1'b0, 8'h11});
    chk("R8 head before simultaneous", {rd_last, rd_data}, model_q.pop_front());
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    chk("R11 count unchanged on dual transfer", free_cnt, 226);

    // random streams
    random_run(1'b0, 4000);
    random_run(1'b1, 4000);

    summary();
    $finish;
  end

endmodule